// File: doc/BRIEF.md
# Simultaneous-Sampling Conversion Sequencer

This block is the digital control core of a four-channel converter whose sample-holds all freeze at the same instant. A rising edge on the start input puts every sample-hold into hold. It also captures a channel mask and raises `busy_o`. The block then converts the selected channels one at a time, lowest channel number first. Each conversion takes a fixed number of clock cycles, and `eoc_n_o` pulses low for one cycle as each channel completes. The converted value for each channel is a code supplied on `code_i`. That code is captured at the start edge, in the same way the sample-holds freeze. Analog behaviour is not modelled.

The mask comes from one of two sources, chosen by `src_sel_i`. With `src_sel_i` at 0 it is taken from four select pins. With `src_sel_i` at 1 it is taken from a 4-bit channel register, which is written over the low data lines using a chip-select and write strobe. Results are placed in a small buffer in the order they were converted. A host reads them one per chip-select plus read strobe.

When the sequence ends, the sample-holds return to track. A ready flag then stays low for a programmable acquisition interval.

The controller has four states:
- ST_TRACK: idle and tracking.
- ST_CONVERT: one channel at a time is converted.
- ST_EMPTY: a one-cycle busy state used when the captured mask is empty.
- ST_ACQUIRE: the acquisition interval.

Its transitions are:
- ST_TRACK to ST_CONVERT, on an accepted start with a non-empty mask.
- ST_TRACK to ST_EMPTY, on an accepted start with an empty mask.
- ST_CONVERT to ST_ACQUIRE, when the last selected channel completes.
- ST_EMPTY to ST_ACQUIRE, always, after one cycle.
- ST_ACQUIRE to ST_TRACK, when the acquisition count expires.
- ST_ACQUIRE to ST_CONVERT or ST_EMPTY, on a new accepted start.

Top module: `simsamp_seq`

## Requirements
- R1: After reset:
  - `busy_o` = 0, `hold_o` = 0, `eoc_n_o` = 1 and `ready_o` = 1.
  - `rdata_o` reads 0.
  - The channel register holds 4'b1111.
- R2: The mask is taken from `sel_pins_i` when `src_sel_i` = 0 and from the channel register when `src_sel_i` = 1. In both sources, bit 0 selects channel 1 and bit 3 selects channel 4.
- R3: The channel register loads `wdata_i` on a rising edge of `wr_n_i`, but only while `cs_n_i` = 0 and `rd_n_i` = 1. A write strobe under any other condition leaves it unchanged.
- R4: The mask is captured on the clock edge that first sees `start_i` high. Changes to the pins, the register or `src_sel_i` after that edge take effect only at the next start.
- R5: Selected channels are converted and read out in ascending channel order. Unselected channels produce no result.
- R6: `busy_o` (and `hold_o` with it) rises on the start edge and stays high for exactly N×CONV_CYC cycles, where N is the number of selected channels.
- R7: `eoc_n_o` is low for exactly one cycle at the end of each channel's conversion. Its last pulse coincides with the cycle in which `busy_o` falls.
- R8: Each result is the value `code_i` held at the start edge. Changes to `code_i` during the sequence do not affect the results.
- R9: A start rising edge while `busy_o` is high is ignored. The mask, the captured codes and the read pointer are not touched.
- R10: A start with an empty mask holds `busy_o` high for one cycle, produces no `eoc_n_o` pulse and stores no result.
- R11: After `busy_o` falls, `ready_o` stays low for exactly ACQ_CYC cycles.
- R12: Result reads work as follows:
  - While `cs_n_i` and `rd_n_i` are both low, `rdata_o` shows the result at the read pointer.
  - A rising edge of `rd_n_i` with `cs_n_i` low advances the pointer.
  - A read beyond the results stored so far returns 0 and does not advance the pointer.
  - An accepted start clears the buffer and the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion start; its rising edge is acted on |
| src_sel_i | input | 1 | Mask source: 0 = select pins, 1 = channel register |
| sel_pins_i | input | NUM_CH | Hardware channel select, bit 0 = channel 1 |
| cs_n_i | input | 1 | Chip select, active low |
| rd_n_i | input | 1 | Read strobe, active low |
| wr_n_i | input | 1 | Write strobe, active low; register loads on its rising edge |
| wdata_i | input | NUM_CH | Low data lines feeding the channel register |
| code_i | input | NUM_CH*CODE_W | Per-channel conversion codes, channel 1 in the low bits |
| busy_o | output | 1 | High for the whole conversion sequence |
| eoc_n_o | output | 1 | One-cycle low pulse at each channel's end |
| hold_o | output | 1 | Sample-holds in hold |
| ready_o | output | 1 | Low during the sequence and the acquisition interval |
| rdata_o | output | CODE_W | Result at the read pointer during a read, else 0 |

## Verification
The assertions take four things for granted about the inputs:
- `start_i`, `rd_n_i` and `wr_n_i` are synchronous levels that each hold for at least one clock, so every edge the block reacts to is seen by the clock.
- CONV_CYC is at least 2, so an end-of-conversion pulse is always followed by a cycle with `eoc_n_o` high.
- A result write never arrives while the buffer is already full.
- No read strobe is in progress in the same cycle a start is accepted.

The bench respects all of this. It drives every input on the falling clock edge and holds each strobe level for a full cycle. It uses a conversion time of eight cycles. It places reads only between sequences, or in the gap between two channel completions.

// File: rtl/simsamp_pkg.sv
package simsamp_pkg;

    // Controller states
    typedef enum logic [1:0] {
        ST_TRACK   = 2'd0,
        ST_CONVERT = 2'd1,
        ST_EMPTY   = 2'd2,
        ST_ACQUIRE = 2'd3
    } seq_state_t;

endpackage

// File: rtl/simsamp_chreg.sv
// Channel select register written over the low data lines.
module simsamp_chreg #(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_i,
    input  logic              rd_n_i,
    input  logic              wr_n_i,
    input  logic [NUM_CH-1:0] wdata_i,
    output logic [NUM_CH-1:0] chsel_o
);

    logic wr_q;
    logic load;

    // Load on the write strobe's rising edge, only during a valid write cycle
    assign load = ~wr_q & wr_n_i & ~cs_n_i & rd_n_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q    <= 1'b1;
            chsel_o <= '1;
        end else begin
            wr_q <= wr_n_i;
            if (load) begin
                chsel_o <= wdata_i;
            end
        end
    end

    // R3: with chip select inactive the register cannot change
    assert_reg_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_i |=> $stable(chsel_o));

endmodule

// File: rtl/simsamp_fsm.sv
// Sequencing controller: start capture, channel walk, busy/EOC/ready timing.
module simsamp_fsm
    import simsamp_pkg::*;
#(
    parameter int NUM_CH   = 4,
    parameter int CODE_W   = 12,
    parameter int CONV_CYC = 8,
    parameter int ACQ_CYC  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic                     src_sel_i,
    input  logic [NUM_CH-1:0]        sel_pins_i,
    input  logic [NUM_CH-1:0]        chsel_i,
    input  logic [NUM_CH*CODE_W-1:0] code_i,
    output logic                     busy_o,
    output logic                     hold_o,
    output logic                     eoc_n_o,
    output logic                     ready_o,
    output logic                     clr_o,
    output logic                     res_we_o,
    output logic [CODE_W-1:0]        res_data_o
);

    localparam int IDX_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int CNT_MAX = (CONV_CYC > ACQ_CYC) ? CONV_CYC : ACQ_CYC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] CONV_LAST = CNT_W'(CONV_CYC - 1);
    localparam logic [CNT_W-1:0] ACQ_LAST  = CNT_W'(ACQ_CYC - 1);

    seq_state_t        st_q;
    seq_state_t        st_nx;
    logic              start_q;
    logic              start_rise;
    logic              accept;
    logic [NUM_CH-1:0] pick;
    logic [NUM_CH-1:0] mask_cap;
    logic [NUM_CH-1:0] rem_q;
    logic [NUM_CH-1:0] cur_bit;
    logic [IDX_W-1:0]  cur_idx;
    logic [CNT_W-1:0]  cnt_q;
    logic              conv_last;
    logic [CODE_W-1:0] held_q [NUM_CH];

    assign start_rise = start_i & ~start_q;
    assign accept     = start_rise && (st_q == ST_TRACK || st_q == ST_ACQUIRE);
    assign pick       = src_sel_i ? chsel_i : sel_pins_i;
    assign conv_last  = (st_q == ST_CONVERT) && (cnt_q == CONV_LAST);

    // Lowest remaining channel is converted next (ascending order)
    always_comb begin
        cur_idx = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (rem_q[i]) begin
                cur_idx = IDX_W'(i);
            end
        end
        cur_bit          = '0;
        cur_bit[cur_idx] = 1'b1;
    end

    // Next-state logic
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ST_TRACK: begin
                if (accept) begin
                    st_nx = (pick == '0) ? ST_EMPTY : ST_CONVERT;
                end
            end
            ST_CONVERT: begin
                if (conv_last && ((rem_q & ~cur_bit) == '0)) begin
                    st_nx = ST_ACQUIRE;
                end
            end
            ST_EMPTY: begin
                st_nx = ST_ACQUIRE;
            end
            ST_ACQUIRE: begin
                if (accept) begin
                    st_nx = (pick == '0) ? ST_EMPTY : ST_CONVERT;
                end else if (cnt_q == ACQ_LAST) begin
                    st_nx = ST_TRACK;
                end
            end
            default: st_nx = ST_TRACK;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= ST_TRACK;
            start_q <= 1'b0;
        end else begin
            st_q    <= st_nx;
            start_q <= start_i;
        end
    end

    // Mask, held samples and cycle counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            rem_q    <= '0;
            mask_cap <= '0;
            for (int i = 0; i < NUM_CH; i++) begin
                held_q[i] <= '0;
            end
        end else if (accept) begin
            cnt_q    <= '0;
            rem_q    <= pick;
            mask_cap <= pick;
            for (int i = 0; i < NUM_CH; i++) begin
                held_q[i] <= code_i[i*CODE_W +: CODE_W];
            end
        end else if (st_q == ST_CONVERT) begin
            if (conv_last) begin
                cnt_q <= '0;
                rem_q <= rem_q & ~cur_bit;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else if (st_q == ST_ACQUIRE) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign clr_o      = accept;
    assign res_we_o   = conv_last;
    assign res_data_o = held_q[cur_idx];

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_o  <= 1'b0;
            hold_o  <= 1'b0;
            eoc_n_o <= 1'b1;
            ready_o <= 1'b1;
        end else begin
            busy_o  <= (st_nx == ST_CONVERT) || (st_nx == ST_EMPTY);
            hold_o  <= (st_nx == ST_CONVERT) || (st_nx == ST_EMPTY);
            eoc_n_o <= ~conv_last;
            ready_o <= (st_nx == ST_TRACK);
        end
    end

    // R7: end-of-conversion strobe lasts one cycle
    assert_eoc_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !eoc_n_o |=> eoc_n_o);

    // R7: a strobe only follows a busy cycle
    assert_eoc_in_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !eoc_n_o |-> $past(busy_o));

    // R6: busy rises only after a start level was seen
    assert_busy_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

    // R4: captured mask frozen while the sequence runs
    assert_mask_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(mask_cap));

    // R9: no start accepted while busy
    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !clr_o);

    // R11: acquisition interval follows the end of busy
    assert_ready_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> !ready_o);

endmodule

// File: rtl/simsamp_rbuf.sv
// Result buffer filled in conversion order, read through chip select + read strobe.
module simsamp_rbuf #(
    parameter int NUM_CH = 4,
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              we_i,
    input  logic [CODE_W-1:0] wdata_i,
    input  logic              cs_n_i,
    input  logic              rd_n_i,
    output logic [CODE_W-1:0] rdata_o
);

    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int CNT_W = $clog2(NUM_CH + 1);
    localparam logic [CNT_W-1:0] DEPTH = CNT_W'(NUM_CH);

    logic [CODE_W-1:0] mem [NUM_CH];
    logic [CNT_W-1:0]  wcnt_q;
    logic [CNT_W-1:0]  rptr_q;
    logic              rd_q;
    logic              rd_done;
    logic              avail;

    assign avail   = rptr_q < wcnt_q;
    assign rd_done = ~rd_q & rd_n_i & ~cs_n_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= 1'b1;
        end else begin
            rd_q <= rd_n_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wcnt_q <= '0;
            rptr_q <= '0;
        end else if (clr_i) begin
            wcnt_q <= '0;
            rptr_q <= '0;
        end else begin
            if (we_i && (wcnt_q < DEPTH)) begin
                wcnt_q <= wcnt_q + 1'b1;
            end
            if (rd_done && avail) begin
                rptr_q <= rptr_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (we_i && (wcnt_q < DEPTH)) begin
            mem[wcnt_q[IDX_W-1:0]] <= wdata_i;
        end
    end

    assign rdata_o = (!cs_n_i && !rd_n_i && avail) ? mem[rptr_q[IDX_W-1:0]] : '0;

    // R12: the sequencer never writes more results than the buffer holds
    assert_no_overflow_R12: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |-> (wcnt_q < DEPTH));

    // R12: a new start empties the read side
    assert_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (rptr_q == '0 && wcnt_q == '0));

endmodule

// File: rtl/simsamp_seq.sv
// Top: simultaneous-sampling conversion sequencer.
module simsamp_seq #(
    parameter int NUM_CH   = 4,
    parameter int CODE_W   = 12,
    parameter int CONV_CYC = 8,
    parameter int ACQ_CYC  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic                     src_sel_i,
    input  logic [NUM_CH-1:0]        sel_pins_i,
    input  logic                     cs_n_i,
    input  logic                     rd_n_i,
    input  logic                     wr_n_i,
    input  logic [NUM_CH-1:0]        wdata_i,
    input  logic [NUM_CH*CODE_W-1:0] code_i,
    output logic                     busy_o,
    output logic                     eoc_n_o,
    output logic                     hold_o,
    output logic                     ready_o,
    output logic [CODE_W-1:0]        rdata_o
);

    logic [NUM_CH-1:0] chsel;
    logic              clr;
    logic              res_we;
    logic [CODE_W-1:0] res_data;

    simsamp_chreg #(.NUM_CH(NUM_CH)) u_chreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n_i  (cs_n_i),
        .rd_n_i  (rd_n_i),
        .wr_n_i  (wr_n_i),
        .wdata_i (wdata_i),
        .chsel_o (chsel)
    );

    simsamp_fsm #(
        .NUM_CH   (NUM_CH),
        .CODE_W   (CODE_W),
        .CONV_CYC (CONV_CYC),
        .ACQ_CYC  (ACQ_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .src_sel_i  (src_sel_i),
        .sel_pins_i (sel_pins_i),
        .chsel_i    (chsel),
        .code_i     (code_i),
        .busy_o     (busy_o),
        .hold_o     (hold_o),
        .eoc_n_o    (eoc_n_o),
        .ready_o    (ready_o),
        .clr_o      (clr),
        .res_we_o   (res_we),
        .res_data_o (res_data)
    );

    simsamp_rbuf #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_rbuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (clr),
        .we_i    (res_we),
        .wdata_i (res_data),
        .cs_n_i  (cs_n_i),
        .rd_n_i  (rd_n_i),
        .rdata_o (rdata_o)
    );

endmodule

// File: tb/simsamp_seq_tb.sv
`timescale 1ns/1ps
module simsamp_seq_tb;

    localparam int NCH  = 4;
    localparam int CW   = 12;
    localparam int CONV = 8;
    localparam int ACQ  = 5;

    // {src_sel, pins[3:0], register value[3:0]}
    localparam logic [8:0] VECS [6] = '{
        9'b0_1101_0010,
        9'b1_1111_1010,
        9'b0_1000_0001,
        9'b1_0000_1111,
        9'b0_0110_0000,
        9'b1_1001_0100
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              src_sel = 1'b0;
    logic [NCH-1:0]    pins = '0;
    logic              cs_n = 1'b1;
    logic              rd_n = 1'b1;
    logic              wr_n = 1'b1;
    logic [NCH-1:0]    wdata = '0;
    logic [NCH*CW-1:0] codes = '0;
    logic              busy, eoc_n, hold, ready;
    logic [CW-1:0]     rdata;

    int checks = 0;
    int failures = 0;
    int n_busy = 0, n_eoc = 0, n_rdy = 0, n_mis = 0;
    int b0, e0, r0, m0;

    always #10 clk = ~clk;

    simsamp_seq #(.NUM_CH(NCH), .CODE_W(CW), .CONV_CYC(CONV), .ACQ_CYC(ACQ)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .src_sel_i(src_sel),
        .sel_pins_i(pins), .cs_n_i(cs_n), .rd_n_i(rd_n), .wr_n_i(wr_n),
        .wdata_i(wdata), .code_i(codes), .busy_o(busy), .eoc_n_o(eoc_n),
        .hold_o(hold), .ready_o(ready), .rdata_o(rdata)
    );

    // Output monitor, sampled on the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            n_busy = n_busy + (busy ? 1 : 0);
            n_eoc  = n_eoc + (eoc_n ? 0 : 1);
            n_rdy  = n_rdy + (ready ? 0 : 1);
            n_mis  = n_mis + ((hold != busy) ? 1 : 0);
        end
    end

    function automatic logic [CW-1:0] code_val(input int seed, input int ch);
        return CW'((seed * 37 + ch * 211 + 9) % 4096);
    endfunction

    function automatic logic [NCH*CW-1:0] mk_codes(input int seed);
        logic [NCH*CW-1:0] v;
        for (int c = 0; c < NCH; c++) v[c*CW +: CW] = code_val(seed, c);
        return v;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [NCH-1:0] v, input logic csv, input logic rdv);
        @(negedge clk); cs_n = csv; rd_n = rdv; wdata = v;
        @(negedge clk); wr_n = 1'b0;
        @(negedge clk); wr_n = 1'b1;
        @(negedge clk); cs_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic rd_once(output logic [CW-1:0] d);
        @(negedge clk); cs_n = 1'b0; rd_n = 1'b0;
        @(negedge clk); d = rdata; rd_n = 1'b1;
        @(negedge clk); cs_n = 1'b1;
    endtask

    task automatic launch(input logic src, input logic [NCH-1:0] p, input int seed);
        src_sel = src; pins = p; codes = mk_codes(seed);
        @(posedge clk); b0 = n_busy; e0 = n_eoc; r0 = n_rdy; m0 = n_mis;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        codes = ~mk_codes(seed);          // R8: later code changes must not matter
    endtask

    task automatic wait_done();
        for (int k = 0; k < 2000; k++) begin
            @(negedge clk);
            if (!busy && ready) break;
        end
        @(posedge clk);
    endtask

    task automatic finish_seq(input int pop, input string tag);
        wait_done();
        chk({tag, " R6 busy cycles"}, n_busy - b0, (pop == 0) ? 1 : pop * CONV);
        chk({tag, " R7 eoc pulses"}, n_eoc - e0, pop);
        chk({tag, " R11 ready low cycles"}, n_rdy - r0, ACQ + ((pop == 0) ? 1 : pop * CONV));
        chk({tag, " R6 hold tracks busy"}, n_mis - m0, 0);
    endtask

    task automatic read_all(input int seed, input logic [NCH-1:0] mask, input string tag);
        logic [CW-1:0] d;
        for (int c = 0; c < NCH; c++) begin
            if (mask[c]) begin
                rd_once(d);
                chk({tag, " R5 R8 R2 ascending result"}, int'(d), int'(code_val(seed, c)));
            end
        end
        rd_once(d);
        chk({tag, " R12 read past end"}, int'(d), 0);
    endtask

    initial begin
        #(20 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [CW-1:0] d;
        logic [NCH-1:0] m;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 busy", int'(busy), 0);
        chk("R1 hold", int'(hold), 0);
        chk("R1 eoc_n", int'(eoc_n), 1);
        chk("R1 ready", int'(ready), 1);
        rd_once(d);
        chk("R1 rdata empty", int'(d), 0);

        // R1 R2: register reset value selects all channels
        launch(1'b1, 4'b0000, 1);
        finish_seq(4, "reset-reg");
        read_all(1, 4'b1111, "R1 reset-reg");

        // Vector table
        for (int i = 0; i < 6; i++) begin
            wr_reg(VECS[i][3:0], 1'b0, 1'b1);
            m = VECS[i][8] ? VECS[i][3:0] : VECS[i][7:4];
            launch(VECS[i][8], VECS[i][7:4], 10 + i);
            finish_seq($countones(m), "vec");
            read_all(10 + i, m, "vec");
        end

        // R3: strobes outside a valid write cycle do not load
        wr_reg(4'b0011, 1'b0, 1'b1);
        wr_reg(4'b1100, 1'b1, 1'b1);
        wr_reg(4'b1000, 1'b0, 1'b0);
        launch(1'b1, 4'b1111, 30);
        finish_seq(2, "R3 ignored write");
        read_all(30, 4'b0011, "R3 ignored write");

        // R4: mask frozen at the start edge; changes apply next start
        wr_reg(4'b0101, 1'b0, 1'b1);
        launch(1'b0, 4'b1010, 31);
        repeat (3) @(negedge clk);
        pins = 4'b0001; src_sel = 1'b1;
        finish_seq(2, "R4 frozen");
        read_all(31, 4'b1010, "R4 frozen");
        launch(1'b0, 4'b0001, 32);
        finish_seq(1, "R4 next start");
        read_all(32, 4'b0001, "R4 next start");

        // R9: second start during busy ignored
        launch(1'b0, 4'b1111, 33);
        repeat (CONV + 2) @(negedge clk);
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        finish_seq(4, "R9 start in busy");
        read_all(33, 4'b1111, "R9 start in busy");

        // R10: empty mask
        launch(1'b0, 4'b0000, 34);
        finish_seq(0, "R10 empty");
        rd_once(d);
        chk("R10 no result stored", int'(d), 0);

        // R12: read between two channel completions
        launch(1'b0, 4'b0110, 35);
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (!eoc_n) break;
        end
        rd_once(d);
        chk("R12 first result mid-sequence", int'(d), int'(code_val(35, 1)));
        rd_once(d);
        chk("R12 not yet available", int'(d), 0);
        wait_done();
        rd_once(d);
        chk("R12 pointer held then advances", int'(d), int'(code_val(35, 2)));
        rd_once(d);
        chk("R12 past end after sequence", int'(d), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule